// File: doc/BRIEF.md
# Pipelined Converter Stage Merger and Error Corrector

This block sits behind the analog stages of a three-stage pipelined 8-bit converter. The first and second stages each resolve a 3-bit coarse code, and the third stage resolves a 4-bit fine code. Each code becomes valid half a clock after the one before it. The block captures every code on the edge where that code is settled. It then brings the three codes of one sample into a common rising-edge cycle and merges them into one straight-binary 8-bit word.

The merge is an overlapped sum. The most significant bit of each later stage lines up with the least significant bit of the stage before it, so a decision error in an earlier stage is absorbed by the carries. A fixed offset is then removed, and the result is clipped into the 0 to 255 range. The corrected word is registered into an output latch. One new word leaves every clock, and each word belongs to the sample taken three rising edges earlier.

After reset, the latch reads zero and the valid flag stays low until the pipeline has filled. An active-low output enable parks the data bus, and it leaves the pipeline running.

Top module: `pipeAdcCorrector`

## Requirements
- R1: While `rstN` is low, and after reset until `dataValid` first rises, `dataOut` reads 0 and `dataValid` reads 0 (with `outEnN` low).
- R2: Take the first rising edge with `rstN` high as sample edge 0. `dataValid` rises just after sample edge 3 and then stays high until the next reset.
- R3: The word on `dataOut` just after sample edge k+3 is the corrected code of sample k. A new word appears every cycle.
- R4: The word is `32*c1 + 8*c2 + c3 - 20`, where c1, c2 and c3 are the codes of stages 1, 2 and 3. With this rule, a stage-1 decision error of up to ±16 LSB and a stage-2 error of up to ±4 LSB leave the output equal to the ideal code.
- R5: A merged value above 255 is output as 255. The value 255 itself passes unchanged.
- R6: A merged value below 0 (underflow) is output as 0.
- R7: When `outEnN` is high, `dataHiZ` is 1 and `dataOut` is 0 in the same cycle. When `outEnN` is low, `dataHiZ` is 0 and the latched word is driven.
- R8: `outEnN` has no effect on the pipeline. Words for samples taken while the output was disabled come out correct once it is enabled again.
- R9: Each stage code is used only at its own edge. Stage 1 and stage 3 codes are taken at the falling edge: stage 1 half a cycle after sample edge k, stage 3 for sample k at the falling edge after edge k+1. The stage 2 code for sample k is taken at rising edge k+1. Values at other times have no effect.
- R10: The output is straight binary: code 0 is the bottom of the range, 128 is mid-scale and 255 is full scale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, one sample per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| stage1Code | input | 3 | Coarse code of stage 1, taken on the falling edge |
| stage2Code | input | 3 | Code of stage 2, taken on the rising edge |
| stage3Code | input | 4 | Fine code of stage 3, taken on the falling edge |
| outEnN | input | 1 | Active-low output enable |
| dataOut | output | 8 | Corrected sample word, reads 0 while disabled |
| dataHiZ | output | 1 | High when the bus must be high-impedance |
| dataValid | output | 1 | Pipeline filled, `dataOut` carries real samples |

## Verification
The bench builds the block with its default stage widths of 3, 3 and 4 bits. With these widths, the weights are 32, 8 and 1 and the offset is 20. At this size a small quantiser model in the bench can reach every corner of the redundancy window. That model injects stage-1 comparator offsets of ±16 LSB and stage-2 offsets of ±4 LSB. It also drives inputs beyond both ends of the range, which gives the clip-high and underflow paths a workout. Stage codes are replaced with junk during the half cycles when they must be ignored. This proves the edge alignment and the three-clock latency, not just the arithmetic.

// File: rtl/adcCorrPkg.sv
package adcCorrPkg;
  // Strobes passed from the fill controller to the datapath.
  typedef struct packed {
    logic loadOut;    // update the output latch this cycle
    logic wordValid;  // latch holds a real sample
  } ctrlStrobes_t;

  localparam int FILL_EDGES = 3;  // rising edges from sample to output
endpackage

// File: rtl/adcPhaseCapture.sv
module adcPhaseCapture #(
  parameter int W = 3,
  parameter bit ON_FALL = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (ON_FALL) begin : gFall
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= d;
      end
    end else begin : gRise
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/adcCorrCtrl.sv
module adcCorrCtrl
  import adcCorrPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  output ctrlStrobes_t strb
);
  localparam int CW = $clog2(FILL_EDGES + 1);
  localparam logic [CW-1:0] FULL = CW'(FILL_EDGES);

  logic [CW-1:0] fillCnt;
  logic          validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                fillCnt <= '0;
    else if (fillCnt != FULL) fillCnt <= fillCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= (fillCnt == FULL);
  end

  assign strb.loadOut   = (fillCnt == FULL);
  assign strb.wordValid = validQ;

  AST_VALID_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wordValid |=> strb.wordValid); // R2
  AST_FULL_THROUGHPUT: assert property (@(posedge clk) disable iff (!rstN)
    strb.wordValid |-> strb.loadOut); // R3
endmodule

// File: rtl/adcCorrDatapath.sv
module adcCorrDatapath
  import adcCorrPkg::*;
#(
  parameter int S1W = 3,
  parameter int S2W = 3,
  parameter int S3W = 4,
  localparam int OUTW = S1W + S2W + S3W - 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strb,
  input  logic [S1W-1:0]  stage1Code,
  input  logic [S2W-1:0]  stage2Code,
  input  logic [S3W-1:0]  stage3Code,
  output logic [OUTW-1:0] outWord
);
  localparam int SH2  = S3W - 1;
  localparam int SH1  = SH2 + S2W - 1;
  localparam int SUMW = S1W + SH1 + 2;
  localparam int OFF2 = 1 << (S2W - 2 + SH2);
  localparam int OFF3 = 1 << (S3W - 2);
  localparam logic signed [SUMW-1:0] OFFT = SUMW'(OFF2 + OFF3);
  localparam logic signed [SUMW-1:0] TOPC = SUMW'((1 << OUTW) - 1);

  logic [S1W-1:0] s1Fall, s1Mid, a1;
  logic [S2W-1:0] s2Rise, a2;
  logic [S3W-1:0] s3Fall, a3;

  adcPhaseCapture #(.W(S1W), .ON_FALL(1'b1)) cap1_i (
    .clk(clk), .rstN(rstN), .d(stage1Code), .q(s1Fall));
  adcPhaseCapture #(.W(S2W), .ON_FALL(1'b0)) cap2_i (
    .clk(clk), .rstN(rstN), .d(stage2Code), .q(s2Rise));
  adcPhaseCapture #(.W(S3W), .ON_FALL(1'b1)) cap3_i (
    .clk(clk), .rstN(rstN), .d(stage3Code), .q(s3Fall));

  // Stage 1 needs one more rising stage to meet stage 2 and 3.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Mid <= '0;
      a1    <= '0;
      a2    <= '0;
      a3    <= '0;
    end else begin
      s1Mid <= s1Fall;
      a1    <= s1Mid;
      a2    <= s2Rise;
      a3    <= s3Fall;
    end
  end

  logic signed [SUMW-1:0] rawSum;
  logic [OUTW-1:0]        corrected;

  always_comb begin
    rawSum = $signed((SUMW'(a1) << SH1) + (SUMW'(a2) << SH2) + SUMW'(a3)) - OFFT;
    if (rawSum < 0)         corrected = '0;
    else if (rawSum > TOPC) corrected = '1;
    else                    corrected = rawSum[OUTW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outWord <= '0;
    else if (strb.loadOut) outWord <= corrected;
  end

  AST_QUIET_UNTIL_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wordValid |-> outWord == '0); // R1
  AST_CLIP_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadOut && rawSum > TOPC) |=> outWord == TOPC[OUTW-1:0]); // R5
  AST_CLIP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadOut && rawSum < 0) |=> outWord == '0); // R6
endmodule

// File: rtl/pipeAdcCorrector.sv
module pipeAdcCorrector
  import adcCorrPkg::*;
#(
  parameter int S1W = 3,
  parameter int S2W = 3,
  parameter int S3W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [S1W-1:0]           stage1Code,
  input  logic [S2W-1:0]           stage2Code,
  input  logic [S3W-1:0]           stage3Code,
  input  logic                     outEnN,
  output logic [S1W+S2W+S3W-3:0]   dataOut,
  output logic                     dataHiZ,
  output logic                     dataValid
);
  localparam int OUTW = S1W + S2W + S3W - 2;

  ctrlStrobes_t    strb;
  logic [OUTW-1:0] outWord;

  adcCorrCtrl ctrl_i (.clk(clk), .rstN(rstN), .strb(strb));

  adcCorrDatapath #(.S1W(S1W), .S2W(S2W), .S3W(S3W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .stage1Code(stage1Code), .stage2Code(stage2Code), .stage3Code(stage3Code),
    .outWord(outWord));

  assign dataHiZ   = outEnN;
  assign dataOut   = outEnN ? '0 : outWord;
  assign dataValid = strb.wordValid;
endmodule

// File: tb/pipeAdcCorrector_tb_top.sv
module pipeAdcCorrector_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] stage1Code = '0;
  logic [2:0] stage2Code = '0;
  logic [3:0] stage3Code = '0;
  logic       outEnN = 1'b0;
  logic [7:0] dataOut;
  logic       dataHiZ, dataValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pipeAdcCorrector dut_i (
    .clk(clk), .rstN(rstN), .stage1Code(stage1Code), .stage2Code(stage2Code),
    .stage3Code(stage3Code), .outEnN(outEnN), .dataOut(dataOut),
    .dataHiZ(dataHiZ), .dataValid(dataValid));

  // Stimulus table: analog level, stage-1 offset, stage-2 offset, expected code.
  localparam int NV = 20;
  localparam int VEC_V  [NV] = '{0, 128, 255, 31, 32, 100, 100, 200, 200, 63,
                                 64, 255, 0, 260, 300, -5, -40, 7, 77, 250};
  localparam int VEC_D1 [NV] = '{0, 0, 0, 0, 0, 16, -16, 16, -16, -16,
                                 16, 16, -16, 0, 0, 0, 0, 0, 8, -16};
  localparam int VEC_D2 [NV] = '{0, 0, 0, 0, 0, 0, 0, 4, -4, 4,
                                 -4, 4, -4, 0, 0, 0, 0, 0, -2, 4};
  localparam int VEC_E  [NV] = '{0, 128, 255, 31, 32, 100, 100, 200, 200, 63,
                                 64, 255, 0, 255, 255, 0, 0, 7, 77, 250};

  int c1A[64], c2A[64], c3A[64], expA[64];

  function automatic int floorDiv(int a, int b);
    if (a >= 0) return a / b;
    return -((-a + b - 1) / b);
  endfunction

  function automatic int clampI(int x, int lo, int hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  // Quantiser model of the three stages for one sample.
  task automatic modelSample(int idx, int v, int d1, int d2, int e);
    int r1, r2;
    c1A[idx] = clampI(floorDiv(v + d1, 32), 0, 7);
    r1 = v - 32 * c1A[idx];
    c2A[idx] = clampI(floorDiv(r1 + 16 + d2, 8), 0, 7);
    r2 = r1 + 16 - 8 * c2A[idx];
    c3A[idx] = clampI(r2 + 4, 0, 15);
    expA[idx] = e;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Run n samples from the model arrays; disable the bus on cycles in disMask.
  task automatic runStream(int n, bit useDis);
    for (int c = 0; c < n + 3; c++) begin
      @(posedge clk); #1;
      stage1Code = (c < n) ? 3'(c1A[c]) : 3'(c * 5 + 3);
      stage3Code = (c >= 1 && c <= n) ? 4'(c3A[c-1]) : 4'(c * 7 + 1);
      stage2Code = 3'(c * 3 + 6);  // junk until the falling edge, R9
      outEnN = useDis && (c % 5 == 4);
      #1;
      if (c < 3) begin
        chk("R1 dataOut during fill", dataOut, 0);
        chk("R2 valid low during fill", dataValid, 0);
      end else if (outEnN) begin
        chk("R7 hiz flag", dataHiZ, 1);
        chk("R7 data parked", dataOut, 0);
      end else begin
        chk("R2 valid after fill", dataValid, 1);
        chk("R7 driven", dataHiZ, 0);
        chk("R3 R4 R5 R6 R8 R9 R10 corrected word", dataOut, expA[c-3]);
      end
      @(negedge clk); #1;
      stage1Code = 3'(c * 3 + 2);   // junk after its capture edge, R9
      stage3Code = 4'(c * 11 + 5);  // junk after its capture edge, R9
      stage2Code = (c < n) ? 3'(c2A[c]) : 3'(c + 1);
    end
    outEnN = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NV; i++) modelSample(i, VEC_V[i], VEC_D1[i], VEC_D2[i], VEC_E[i]);
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset dataOut", dataOut, 0);
    chk("R1 reset valid", dataValid, 0);
    @(negedge clk); #1;
    rstN = 1'b1;
    runStream(NV, 1'b0);

    // Mid-run reset, then refill with output disable toggling (R8).
    @(negedge clk); #1;
    rstN = 1'b0;
    #2;
    chk("R1 reset mid-run dataOut", dataOut, 0);
    chk("R1 reset mid-run valid", dataValid, 0);
    @(negedge clk); #1;
    rstN = 1'b1;
    runStream(NV, 1'b1);

    // Directed: R10 scale points, then R5/R6 extremes.
    modelSample(0, 128, 0, 0, 128);
    modelSample(1, 400, 0, 0, 255);
    modelSample(2, -100, 0, 0, 0);
    modelSample(3, 255, -16, -4, 255);
    modelSample(4, 1, 16, 4, 1);
    @(negedge clk); #1;
    rstN = 1'b0;
    @(negedge clk); #1;
    rstN = 1'b1;
    runStream(5, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule